// File: doc/BRIEF.md
# Three-Dimensional DMA Address Sequencer

This block walks the source and destination byte addresses of one transfer. The transfer is described by a loaded parameter set. The transfer is a block of frames, each frame is a run of arrays, and each array is a run of consecutive bytes. Two signed steps apply to each side, source and destination. The array step moves the start address from one array to the next. The frame step moves the start address from one frame to the next. Each clock cycle of data movement produces one source/destination byte-address pair.

Data movement is paced by sync events. There are two modes. In the array-paced mode, one event releases one array, and frames after the first take their array count from a separate reload field. In the frame-paced mode, one event releases a whole frame, and every frame holds the loaded array count. An event that arrives while data is still moving is remembered as a single pending event. The controller is a three-state machine:
- `ST_IDLE`: nothing is loaded.
- `ST_ARMED`: loaded and waiting for an event.
- `ST_MOVE`: emitting pairs.

Its transitions are:
- load: `ST_IDLE`→`ST_ARMED`.
- event: `ST_ARMED`→`ST_MOVE`.
- continue: `ST_MOVE`→`ST_MOVE`, at the end of an event unit when another event is pending or present.
- pause: `ST_MOVE`→`ST_ARMED`, at the end of an event unit with no event.
- finish: `ST_MOVE`→`ST_IDLE`, on the final pair.

Top module: `dma3d_addr_seq`

## Requirements
- R1: After reset, `idle_o` is 1 and `beat_valid_o`, `evt_done_o` and `blk_done_o` are 0.
- R2: `load_i` is accepted only while `idle_o` is 1. A load at any other time leaves the running transfer unchanged. `sync_evt_i` while idle produces no pairs.
- R3: Field packing follows fixed positions:
  - `cnt_word_i[15:0]` is the byte count per array and `cnt_word_i[31:16]` is the array count per frame.
  - In `bidx_word_i` and `cidx_word_i`, bits [15:0] hold the source step and bits [31:16] hold the destination step.
  - All steps are two's-complement and sign-extended to the address width.
  - `ab_sync_i`=1 selects frame-paced mode and 0 selects array-paced mode.
  - All counts, including `rld_i`, are at least 1.
- R4: Within an array, each pair's addresses are one greater than the previous pair's. Each next array of a frame starts at the previous array start plus the array step.
- R5: After the last array of a frame, the next frame starts at the previous frame start plus the frame step.
- R6: In array-paced mode, one event emits exactly one array, and `evt_done_o` is high on its last pair. The first frame has the loaded array count. Every later frame has `rld_i` arrays.
- R7: In frame-paced mode, one event emits one whole frame, and `evt_done_o` is high on the frame's last pair. Every frame has the loaded array count.
- R8: `blk_done_o` is high together with the final pair of the block, with `evt_done_o` also high, and `idle_o` is 1 in the next cycle.
- R9: Any number of events that arrive during an event unit, before its last pair, are merged into one pending event. Exactly one further unit then runs, after which the block waits armed.
- R10: An event that is pending or present in the cycle of a unit's last pair starts the next unit in the following cycle, with no gap.
- R11: An event sampled while armed yields the first pair of the unit in the next cycle.
- R12: A step of zero makes every array, or every frame, revisit the same addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | Capture the parameter fields |
| ab_sync_i | input | 1 | 1: frame per event, 0: array per event |
| cnt_word_i | input | 32 | Array count (high half), bytes per array (low half) |
| ccnt_i | input | 16 | Frames per block |
| rld_i | input | 16 | Array count reload for later frames, array-paced mode |
| src_addr_i | input | 32 | Source start address |
| dst_addr_i | input | 32 | Destination start address |
| bidx_word_i | input | 32 | Array steps: destination high, source low |
| cidx_word_i | input | 32 | Frame steps: destination high, source low |
| sync_evt_i | input | 1 | Sync event strobe |
| idle_o | output | 1 | No transfer loaded |
| beat_valid_o | output | 1 | Address pair valid this cycle |
| src_addr_o | output | 32 | Source byte address |
| dst_addr_o | output | 32 | Destination byte address |
| evt_done_o | output | 1 | Last pair of the current event unit |
| blk_done_o | output | 1 | Last pair of the block |

## Verification
Two functions can fall in the same cycle:
- The close of one event unit.
- The arrival of the next event, which can come in that same last-pair cycle or earlier as a pending event.

The bench provokes the overlap in two ways. It asserts the event exactly in the cycle where `evt_done_o` is seen, and it holds the event high across whole blocks. It judges the result by requiring a valid pair in every cycle from the first pair to `blk_done_o`. Separately, it checks that several events issued during one unit buy exactly one extra unit. The end-of-block case, where `evt_done_o` and `blk_done_o` coincide, is checked on every block.

// File: rtl/dma3d_pkg.sv
package dma3d_pkg;
    localparam int unsigned DIRS = 2;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_MOVE  = 2'd2
    } seq_state_e;
endpackage

// File: rtl/dma3d_count_nest.sv
module dma3d_count_nest #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             load_i,
    input  logic             adv_i,
    input  logic             ab_i,
    input  logic [CNT_W-1:0] acnt_i,
    input  logic [CNT_W-1:0] bcnt_i,
    input  logic [CNT_W-1:0] ccnt_i,
    input  logic [CNT_W-1:0] rld_i,
    output logic [CNT_W-1:0] a_pos_o,
    output logic             byte_last_o,
    output logic             unit_last_o,
    output logic             blk_last_o,
    output logic             step_arr_o,
    output logic             step_frm_o
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] acnt_q, bcnt_q, rld_q;
    logic [CNT_W-1:0] a_pos_q, b_left_q, c_left_q;
    logic             ab_q;
    logic             frm_end;

    assign byte_last_o = (a_pos_q == acnt_q - ONE);
    assign frm_end     = byte_last_o && (b_left_q == ONE);
    assign blk_last_o  = frm_end && (c_left_q == ONE);
    assign unit_last_o = ab_q ? frm_end : byte_last_o;
    assign step_arr_o  = adv_i && byte_last_o && !frm_end;
    assign step_frm_o  = adv_i && frm_end;
    assign a_pos_o     = a_pos_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            acnt_q   <= '0;
            bcnt_q   <= '0;
            rld_q    <= '0;
            ab_q     <= 1'b0;
            a_pos_q  <= '0;
            b_left_q <= '0;
            c_left_q <= '0;
        end else if (load_i) begin
            acnt_q   <= acnt_i;
            bcnt_q   <= bcnt_i;
            rld_q    <= rld_i;
            ab_q     <= ab_i;
            a_pos_q  <= '0;
            b_left_q <= bcnt_i;
            c_left_q <= ccnt_i;
        end else if (adv_i) begin
            if (!byte_last_o) begin
                a_pos_q <= a_pos_q + ONE;
            end else begin
                a_pos_q <= '0;
                if (!frm_end) begin
                    b_left_q <= b_left_q - ONE;
                end else begin
                    b_left_q <= ab_q ? bcnt_q : rld_q;
                    c_left_q <= c_left_q - ONE;
                end
            end
        end
    end
endmodule

// File: rtl/dma3d_addr_walk.sv
module dma3d_addr_walk #(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned IDX_W  = 16,
    parameter int unsigned CNT_W  = 16
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              load_i,
    input  logic [ADDR_W-1:0] start_i,
    input  logic [IDX_W-1:0]  bidx_i,
    input  logic [IDX_W-1:0]  cidx_i,
    input  logic              step_arr_i,
    input  logic              step_frm_i,
    input  logic [CNT_W-1:0]  a_pos_i,
    output logic [ADDR_W-1:0] addr_o
);
    logic [ADDR_W-1:0] frm_base_q, arr_base_q;
    logic [ADDR_W-1:0] bidx_ext, cidx_ext, next_frm;

    assign bidx_ext = {{(ADDR_W-IDX_W){bidx_i[IDX_W-1]}}, bidx_i};
    assign cidx_ext = {{(ADDR_W-IDX_W){cidx_i[IDX_W-1]}}, cidx_i};
    assign next_frm = frm_base_q + cidx_ext;
    assign addr_o   = arr_base_q + {{(ADDR_W-CNT_W){1'b0}}, a_pos_i};

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            frm_base_q <= '0;
            arr_base_q <= '0;
        end else if (load_i) begin
            frm_base_q <= start_i;
            arr_base_q <= start_i;
        end else if (step_frm_i) begin
            frm_base_q <= next_frm;
            arr_base_q <= next_frm;
        end else if (step_arr_i) begin
            arr_base_q <= arr_base_q + bidx_ext;
        end
    end
endmodule

// File: rtl/dma3d_seq_fsm.sv
module dma3d_seq_fsm
    import dma3d_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic load_i,
    input  logic sync_i,
    input  logic unit_last_i,
    input  logic blk_last_i,
    output logic load_ok_o,
    output logic move_o,
    output logic idle_o,
    output logic evt_done_o,
    output logic blk_done_o
);
    seq_state_e state_q, state_d;
    logic       pend_q, pend_d;

    always_comb begin
        state_d = state_q;
        pend_d  = pend_q;
        unique case (state_q)
            ST_IDLE: begin
                pend_d = 1'b0;
                if (load_i) state_d = ST_ARMED;
            end
            ST_ARMED: begin
                pend_d = 1'b0;
                if (sync_i) state_d = ST_MOVE;
            end
            ST_MOVE: begin
                if (unit_last_i) begin
                    pend_d = 1'b0;
                    if (blk_last_i)            state_d = ST_IDLE;
                    else if (pend_q || sync_i) state_d = ST_MOVE;
                    else                       state_d = ST_ARMED;
                end else if (sync_i) begin
                    pend_d = 1'b1;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= ST_IDLE;
            pend_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            pend_q  <= pend_d;
        end
    end

    always_comb begin
        load_ok_o  = 1'b0;
        move_o     = 1'b0;
        idle_o     = 1'b0;
        evt_done_o = 1'b0;
        blk_done_o = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                idle_o    = 1'b1;
                load_ok_o = load_i;
            end
            ST_ARMED: ;
            ST_MOVE: begin
                move_o     = 1'b1;
                evt_done_o = unit_last_i;
                blk_done_o = blk_last_i;
            end
            default: idle_o = 1'b1;
        endcase
    end
endmodule

// File: rtl/dma3d_addr_seq.sv
module dma3d_addr_seq
    import dma3d_pkg::*;
#(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned CNT_W  = 16,
    parameter int unsigned IDX_W  = 16
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic                 load_i,
    input  logic                 ab_sync_i,
    input  logic [2*CNT_W-1:0]   cnt_word_i,
    input  logic [CNT_W-1:0]     ccnt_i,
    input  logic [CNT_W-1:0]     rld_i,
    input  logic [ADDR_W-1:0]    src_addr_i,
    input  logic [ADDR_W-1:0]    dst_addr_i,
    input  logic [2*IDX_W-1:0]   bidx_word_i,
    input  logic [2*IDX_W-1:0]   cidx_word_i,
    input  logic                 sync_evt_i,
    output logic                 idle_o,
    output logic                 beat_valid_o,
    output logic [ADDR_W-1:0]    src_addr_o,
    output logic [ADDR_W-1:0]    dst_addr_o,
    output logic                 evt_done_o,
    output logic                 blk_done_o
);
    logic             load_ok, move;
    logic             byte_last_w, unit_last, blk_last, step_arr, step_frm;
    logic [CNT_W-1:0] a_pos;
    logic [DIRS-1:0][ADDR_W-1:0] start_a, addr_a;

    assign start_a[0] = src_addr_i;
    assign start_a[1] = dst_addr_i;

    dma3d_seq_fsm u_fsm (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .load_i      (load_i),
        .sync_i      (sync_evt_i),
        .unit_last_i (unit_last),
        .blk_last_i  (blk_last),
        .load_ok_o   (load_ok),
        .move_o      (move),
        .idle_o      (idle_o),
        .evt_done_o  (evt_done_o),
        .blk_done_o  (blk_done_o)
    );

    dma3d_count_nest #(.CNT_W(CNT_W)) u_cnt (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .load_i      (load_ok),
        .adv_i       (move),
        .ab_i        (ab_sync_i),
        .acnt_i      (cnt_word_i[CNT_W-1:0]),
        .bcnt_i      (cnt_word_i[2*CNT_W-1:CNT_W]),
        .ccnt_i      (ccnt_i),
        .rld_i       (rld_i),
        .a_pos_o     (a_pos),
        .byte_last_o (byte_last_w),
        .unit_last_o (unit_last),
        .blk_last_o  (blk_last),
        .step_arr_o  (step_arr),
        .step_frm_o  (step_frm)
    );

    for (genvar gd = 0; gd < DIRS; gd++) begin : g_dir
        dma3d_addr_walk #(
            .ADDR_W (ADDR_W),
            .IDX_W  (IDX_W),
            .CNT_W  (CNT_W)
        ) u_walk (
            .clk_i      (clk_i),
            .rst_ni     (rst_ni),
            .load_i     (load_ok),
            .start_i    (start_a[gd]),
            .bidx_i     (bidx_word_i[gd*IDX_W +: IDX_W]),
            .cidx_i     (cidx_word_i[gd*IDX_W +: IDX_W]),
            .step_arr_i (step_arr),
            .step_frm_i (step_frm),
            .a_pos_i    (a_pos),
            .addr_o     (addr_a[gd])
        );
    end

    assign beat_valid_o = move;
    assign src_addr_o   = addr_a[0];
    assign dst_addr_o   = addr_a[1];
endmodule

// File: rtl/dma3d_addr_seq_chk.sv
module dma3d_addr_seq_chk #(
    parameter int unsigned ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              idle,
    input logic              valid,
    input logic              evt_done,
    input logic              blk_done,
    input logic              byte_last,
    input logic [ADDR_W-1:0] src,
    input logic [ADDR_W-1:0] dst
);
    AST_EVT_ON_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
        evt_done |-> valid); // R6
    AST_BLK_IN_EVT: assert property (@(posedge clk) disable iff (!rst_n)
        blk_done |-> evt_done); // R8
    AST_BLK_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        blk_done |=> idle); // R8
    AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        idle |-> (!valid && !evt_done)); // R2
    AST_SRC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && !byte_last) |=> (valid && src == $past(src) + ADDR_W'(1))); // R4
    AST_DST_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && !byte_last) |=> (valid && dst == $past(dst) + ADDR_W'(1))); // R4
endmodule

bind dma3d_addr_seq dma3d_addr_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk_i),
    .rst_n     (rst_ni),
    .idle      (idle_o),
    .valid     (beat_valid_o),
    .evt_done  (evt_done_o),
    .blk_done  (blk_done_o),
    .byte_last (byte_last_w),
    .src       (src_addr_o),
    .dst       (dst_addr_o)
);

// File: tb/sim_dma3d_addr_seq.sv
module sim_dma3d_addr_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        load = 1'b0, ab = 1'b0, sync = 1'b0;
    logic [31:0] cnt_word = '0, src0 = '0, dst0 = '0, bw = '0, cw = '0;
    logic [15:0] ccnt = '0, rld = '0;
    logic        idle, valid, evt_done, blk_done;
    logic [31:0] src_o, dst_o;

    int vectors = 0, miscompares = 0;
    int m_a, m_b, m_c, m_r, m_ab, m_s0, m_d0, m_sb, m_db, m_sc, m_dc;
    int ea, eb, ec, beats, units;

    always #2 clk = ~clk;

    dma3d_addr_seq u0 (
        .clk_i(clk), .rst_ni(rst_n), .load_i(load), .ab_sync_i(ab),
        .cnt_word_i(cnt_word), .ccnt_i(ccnt), .rld_i(rld),
        .src_addr_i(src0), .dst_addr_i(dst0), .bidx_word_i(bw), .cidx_word_i(cw),
        .sync_evt_i(sync), .idle_o(idle), .beat_valid_o(valid),
        .src_addr_o(src_o), .dst_addr_o(dst_o),
        .evt_done_o(evt_done), .blk_done_o(blk_done)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Monitor: samples 1 ns after each rising edge; expected values from nested indices.
    always @(posedge clk) begin
        #1;
        if (rst_n && valid) begin
            int nb, es, ed;
            bit ul, bl;
            nb = (ec == 0 || m_ab != 0) ? m_b : m_r;
            es = m_s0 + ec*m_sc + eb*m_sb + ea;   // R4 R5
            ed = m_d0 + ec*m_dc + eb*m_db + ea;
            ul = (m_ab != 0) ? (ea == m_a-1 && eb == nb-1) : (ea == m_a-1);
            bl = (ea == m_a-1) && (eb == nb-1) && (ec == m_c-1);
            chk(src_o == 32'(es), "R4/R5 src", src_o, 32'(es));
            chk(dst_o == 32'(ed), "R4/R5 dst", dst_o, 32'(ed));
            chk(evt_done == ul, (m_ab != 0) ? "R7 evt_done" : "R6 evt_done", evt_done, ul);
            chk(blk_done == bl, "R8 blk_done", blk_done, bl);
            beats++;
            if (ul) units++;
            if (ea == m_a-1) begin
                ea = 0;
                if (eb == nb-1) begin eb = 0; ec++; end else eb++;
            end else ea++;
        end else if (rst_n && (evt_done || blk_done)) begin
            chk(1'b0, "R8 done without beat", evt_done, 0);
        end
    end

    task automatic load_cfg(input int a, b, c, r, abm, sb, db, sc, dc);
        m_a = a; m_b = b; m_c = c; m_r = r; m_ab = abm;
        m_s0 = 32'h1000; m_d0 = 32'h8000;
        m_sb = sb; m_db = db; m_sc = sc; m_dc = dc;
        ea = 0; eb = 0; ec = 0; beats = 0; units = 0;
        cnt_word = {16'(b), 16'(a)};   // R3
        ccnt = 16'(c); rld = 16'(r); ab = abm[0];
        src0 = 32'(m_s0); dst0 = 32'(m_d0);
        bw = {16'(db), 16'(sb)}; cw = {16'(dc), 16'(sc)};
        load = 1'b1; @(negedge clk); load = 1'b0;
    endtask

    function automatic int exp_beats();
        return (m_ab != 0) ? m_a*m_b*m_c : m_a*(m_b + (m_c-1)*m_r);
    endfunction
    function automatic int exp_units();
        return (m_ab != 0) ? m_c : (m_b + (m_c-1)*m_r);
    endfunction

    // mode 0: one event whenever armed; mode 1: event held high (no-gap path)
    task automatic run_block(input int mode);
        int guard = 0, gaps = 0;
        bit started = 0;
        if (mode == 0) begin
            while (!idle && guard < 2000) begin
                if (!valid) begin
                    sync = 1'b1; @(negedge clk); sync = 1'b0;
                    chk(valid == 1'b1, "R11 first beat", valid, 1);
                end else @(negedge clk);
                guard++;
            end
        end else begin
            sync = 1'b1;
            while (!idle && guard < 2000) begin
                @(negedge clk);
                if (valid) started = 1;
                else if (started && !idle) gaps++;
                guard++;
            end
            sync = 1'b0;
            chk(gaps == 0, "R10 gapless", gaps, 0);
        end
        chk(beats == exp_beats(), (m_ab != 0) ? "R7 beats" : "R6 beats", beats, exp_beats());
        chk(units == exp_units(), (m_ab != 0) ? "R7 units" : "R6 units", units, exp_units());
        chk(idle == 1'b1, "R8 idle after block", idle, 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "watchdog", 0, 1);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(idle && !valid && !evt_done && !blk_done, "R1 reset state", {idle, valid}, 2);
        rst_n = 1'b1;
        @(negedge clk);

        // R2: event while idle does nothing
        sync = 1'b1; @(negedge clk); sync = 1'b0;
        repeat (3) @(negedge clk);
        chk(idle && !valid, "R2 sync ignored in idle", valid, 0);

        // R2: load during movement ignored (monitor keeps the old configuration)
        load_cfg(4, 2, 1, 1, 0, 16, 32, 0, 0);
        sync = 1'b1; @(negedge clk); sync = 1'b0;
        cnt_word = {16'd9, 16'd9}; src0 = 32'hDEAD0000; load = 1'b1;
        @(negedge clk); load = 1'b0;
        run_block(0);

        // R9: several events during one unit merge into one pending event
        load_cfg(4, 3, 1, 1, 0, 8, 8, 0, 0);
        sync = 1'b1; @(negedge clk); sync = 1'b0;   // beat 0
        sync = 1'b1; @(negedge clk);                // beat 1
        @(negedge clk); sync = 1'b0;                // beat 2
        repeat (8) @(negedge clk);
        chk(units == 2, "R9 merged pending", units, 2);
        chk(!idle && !valid, "R9 waits armed", valid, 0);
        run_block(0);

        // R10: event given exactly in the last-pair cycle of a unit
        load_cfg(3, 2, 1, 1, 0, -4, 4, 0, 0);
        sync = 1'b1; @(negedge clk); sync = 1'b0;
        while (!evt_done) @(negedge clk);
        sync = 1'b1; @(negedge clk); sync = 1'b0;
        chk(valid == 1'b1, "R10 same-cycle event", valid, 1);
        run_block(0);

        // R12: zero steps revisit the same addresses (monitor checks equality per array)
        load_cfg(2, 3, 2, 3, 1, 0, 0, 0, 0);
        run_block(0);

        // Sweep over counts, modes, offset sets and event pacing
        for (int a = 1; a <= 3; a++)
            for (int b = 1; b <= 3; b++)
                for (int c = 1; c <= 2; c++)
                    for (int abm = 0; abm <= 1; abm++)
                        for (int os = 0; os < 3; os++)
                            for (int md = 0; md <= 1; md++) begin
                                int r = (b % 3) + 1;
                                case (os)
                                    0: load_cfg(a, b, c, r, abm, 5, -7, 40, -100);
                                    1: load_cfg(a, b, c, r, abm, 0, 0, 0, 0);   // R12
                                    default: load_cfg(a, b, c, r, abm, -3, 8, -20, 0);
                                endcase
                                run_block(md);
                            end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule